// File: doc/BRIEF.md
# ISA Host Bus Cycle Sequencer

This block sits on the system side of an ISA-style expansion bus and turns single requests into complete bus cycles, clocked once per bus clock. A request carries an address, write data, a read/write flag, an I/O-or-memory flag and a width flag (byte or 16-bit). For each bus cycle the sequencer raises the address latch enable for one clock, puts the address out, and then asserts exactly one command strobe until the cycle ends. On the last clock it captures read data. It then pulses `done_o` together with the read data and an error flag.

The command length comes from a default wait-state count, with separate counts for byte cycles and 16-bit cycles. The slave can stretch the cycle with the channel-ready input or cut it short with the no-wait-state input. A 16-bit request asserts the high-byte enable and checks whether the slave claims 16-bit width. If the slave does not claim it, the request is carried out as two byte cycles: the low byte at the even address, then the high byte at the odd address on the low data lanes.

The ready timer is bounded: when channel-ready stays low past a limit set by software, the cycle is ended anyway and reported as a timeout.

Top module: `isa_cycle_seq`

## Requirements
- R1: A bus cycle starts with `bale_o` high for exactly one clock. During that clock no command strobe is low. `sa_o` does not change while any command strobe is low.
- R2: A byte cycle with channel-ready high and no-wait-state high keeps its command strobe low for W8_WAITS+2 clocks (4 wait states by default, so 6 clocks).
- R3: A claimed 16-bit cycle keeps its command strobe low for W16_WAITS+2 clocks (1 wait state by default).
- R4: Each wait clock in which `chrdy_i` is sampled low adds one clock to the command.
- R5: `nows_ni` sampled low in a wait clock, with `chrdy_i` high, makes that wait clock the last one. This applies to byte cycles and to 16-bit memory cycles.
- R6: `nows_ni` has no effect on claimed 16-bit I/O cycles. This is visible when W16_WAITS is at least 2.
- R7: When `chrdy_i` and `nows_ni` are low in the same wait clock, that clock is a ready-hold clock and the cycle does not end.
- R8: If `chrdy_i` has been low for `tmo_lim_i` wait clocks of a cycle, the next low sample ends the wait anyway, and `tmo_err_o` is high with `done_o`. A request without a timeout reports `tmo_err_o` low.
- R9: A 16-bit request drives `sbhe_no` low for its first cycle. On I/O cycles, `io16_ni` is sampled in the first command clock. On memory cycles, `m16_ni` is sampled in the address clock and again in the first command clock, and a low at either sample claims the width. `io16_ni` is ignored on memory cycles and `m16_ni` is ignored on I/O cycles.
- R10: An unclaimed 16-bit request runs two byte cycles. The second cycle uses address bit 0 set, `sbhe_no` high, and the high byte on `sd_o[7:0]`. Its read byte from `sd_i[7:0]` goes to `rdata_o[15:8]`.
- R11: Read data is captured on the last command clock. For a byte request `rdata_o` is {8'h00, sd_i[7:0]}; for a claimed 16-bit read it is `sd_i`. `done_o` is a single-clock pulse after the last cycle, and `req_ready_o` is high only when no cycle is in progress.
- R12: `sd_oe_o` is high exactly on the command clocks of a write. `sd_o` carries the write data, low byte on `sd_o[7:0]`.
- R13: `smrdc_no`/`smwtc_no` follow `mrdc_no`/`mwtc_no` when address bits above bit 19 are all zero, and stay high otherwise.
- R14: Only one command strobe is low at a time. I/O read uses `iorc_no`, I/O write `iowc_no`, memory read `mrdc_no`, memory write `mwtc_no`. All strobes are high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; taken when `req_ready_o` is high |
| req_ready_o | output | 1 | Sequencer idle |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | 16 | Write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory, 0 = I/O |
| req_wide_i | input | 1 | 1 = 16-bit request |
| tmo_lim_i | input | TMO_W | Ready-hold clocks allowed before timeout |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data, valid with `done_o` |
| tmo_err_o | output | 1 | Timeout flag, valid with `done_o` |
| bale_o | output | 1 | Address latch enable |
| sa_o | output | ADDR_W | Bus address |
| sbhe_no | output | 1 | High byte enable, active low |
| iorc_no | output | 1 | I/O read strobe, active low |
| iowc_no | output | 1 | I/O write strobe, active low |
| mrdc_no | output | 1 | Memory read strobe, active low |
| mwtc_no | output | 1 | Memory write strobe, active low |
| smrdc_no | output | 1 | Lower-1-MB memory read strobe, active low |
| smwtc_no | output | 1 | Lower-1-MB memory write strobe, active low |
| sd_o | output | 16 | Write data to the bus |
| sd_oe_o | output | 1 | Write data drive enable |
| sd_i | input | 16 | Read data from the bus |
| chrdy_i | input | 1 | Channel ready; low adds wait clocks |
| nows_ni | input | 1 | No-wait-state request, active low |
| io16_ni | input | 1 | 16-bit I/O claim, active low |
| m16_ni | input | 1 | 16-bit memory claim, active low |

## Verification
Faults in the wait counter or the ready-hold counter show up as a command strobe that is held too long or too short. The cycle count of the strobe reveals this at the end of the first affected cycle. A wrong width decision shows up within about one cycle as an extra address latch pulse, or a missing one, together with a second address whose bit 0 is wrong. The byte-lane mix-up that follows is visible in `rdata_o` or `sd_o` on the same request. A stale claim sample or a stale timeout flag carried from one request into the next only appears on the following request, so the scenarios are run back to back.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WAIT,
    ST_END
  } seq_st_e;
endpackage

// File: rtl/isa_wait_ctl.sv
module isa_wait_ctl #(
  parameter int CW    = 3,
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CW-1:0]    load_val_i,
  input  logic             active_i,
  input  logic             chrdy_i,
  input  logic             nows_ni,
  input  logic             nows_en_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  output logic             fin_o,
  output logic             tmo_o
);
  logic [CW-1:0]    wcnt_q;
  logic [TMO_W-1:0] tcnt_q;
  logic             hold;

  always_comb begin
    hold  = active_i & ~chrdy_i;
    tmo_o = hold & (tcnt_q == tmo_lim_i);
    // ready-hold wins over the no-wait-state request
    fin_o = active_i & (tmo_o |
            (~hold & ((nows_en_i & ~nows_ni) | (wcnt_q == CW'(1)))));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      tcnt_q <= '0;
    end else if (load_i) begin
      wcnt_q <= load_val_i;
      tcnt_q <= '0;
    end else if (active_i && !fin_o) begin
      if (hold) tcnt_q <= tcnt_q + TMO_W'(1);
      else      wcnt_q <= wcnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/isa_width_sel.sv
module isa_width_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_ph_i,
  input  logic wide_i,
  input  logic mem_i,
  input  logic io16_ni,
  input  logic m16_ni,
  output logic claim_o
);
  logic m16_early_q;

  // first memory-width sample taken in the address clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        m16_early_q <= 1'b0;
    else if (addr_ph_i) m16_early_q <= ~m16_ni;
  end

  assign claim_o = wide_i & (mem_i ? (~m16_ni | m16_early_q) : ~io16_ni);
endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 20
) (
  input  logic              cmd_act_i,
  input  logic              mem_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              iorc_no,
  output logic              iowc_no,
  output logic              mrdc_no,
  output logic              mwtc_no,
  output logic              smrdc_no,
  output logic              smwtc_no
);
  logic low_mb;

  generate
    if (ADDR_W > LOW_W) begin : g_dec
      assign low_mb = ~|addr_i[ADDR_W-1:LOW_W];
    end else begin : g_all
      assign low_mb = 1'b1;
    end
  endgenerate

  assign iorc_no  = ~(cmd_act_i & ~mem_i & ~write_i);
  assign iowc_no  = ~(cmd_act_i & ~mem_i &  write_i);
  assign mrdc_no  = ~(cmd_act_i &  mem_i & ~write_i);
  assign mwtc_no  = ~(cmd_act_i &  mem_i &  write_i);
  assign smrdc_no = mrdc_no | ~low_mb;
  assign smwtc_no = mwtc_no | ~low_mb;
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LOW_W     = 20,
  parameter int W8_WAITS  = 4,
  parameter int W16_WAITS = 1,
  parameter int TMO_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0]  req_wdata_i,
  input  logic              req_write_i,
  input  logic              req_mem_i,
  input  logic              req_wide_i,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  output logic              done_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              tmo_err_o,
  output logic              bale_o,
  output logic [ADDR_W-1:0] sa_o,
  output logic              sbhe_no,
  output logic              iorc_no,
  output logic              iowc_no,
  output logic              mrdc_no,
  output logic              mwtc_no,
  output logic              smrdc_no,
  output logic              smwtc_no,
  output logic [BUS_W-1:0]  sd_o,
  output logic              sd_oe_o,
  input  logic [BUS_W-1:0]  sd_i,
  input  logic              chrdy_i,
  input  logic              nows_ni,
  input  logic              io16_ni,
  input  logic              m16_ni
);
  localparam int WMAX = (W8_WAITS > W16_WAITS) ? W8_WAITS : W16_WAITS;
  localparam int CW   = $clog2(WMAX + 1);
  localparam int HB   = BUS_W / 2;

  seq_st_e             st_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [BUS_W-1:0]    wdata_q, rdata_q;
  logic                write_q, mem_q, wide_q;
  logic                hi_q, split_q, w16_q, err_q, done_q;
  logic                wide_now, claim, cmd_act, fin, tmo;
  logic [CW-1:0]       wait_val;

  assign wide_now = wide_q & ~hi_q;
  assign cmd_act  = (st_q == ST_CMD) | (st_q == ST_WAIT) | (st_q == ST_END);
  assign wait_val = (wide_now & claim) ? CW'(W16_WAITS) : CW'(W8_WAITS);

  isa_width_sel u_width (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_ph_i(st_q == ST_ADDR),
    .wide_i   (wide_now),
    .mem_i    (mem_q),
    .io16_ni  (io16_ni),
    .m16_ni   (m16_ni),
    .claim_o  (claim)
  );

  isa_wait_ctl #(.CW(CW), .TMO_W(TMO_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (st_q == ST_CMD),
    .load_val_i(wait_val),
    .active_i  (st_q == ST_WAIT),
    .chrdy_i   (chrdy_i),
    .nows_ni   (nows_ni),
    .nows_en_i (mem_q | ~w16_q),
    .tmo_lim_i (tmo_lim_i),
    .fin_o     (fin),
    .tmo_o     (tmo)
  );

  isa_strobe_gen #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_strb (
    .cmd_act_i(cmd_act),
    .mem_i    (mem_q),
    .write_i  (write_q),
    .addr_i   (sa_o),
    .iorc_no  (iorc_no),
    .iowc_no  (iowc_no),
    .mrdc_no  (mrdc_no),
    .mwtc_no  (mwtc_no),
    .smrdc_no (smrdc_no),
    .smwtc_no (smwtc_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      write_q <= 1'b0;
      mem_q   <= 1'b0;
      wide_q  <= 1'b0;
      hi_q    <= 1'b0;
      split_q <= 1'b0;
      w16_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          write_q <= req_write_i;
          mem_q   <= req_mem_i;
          wide_q  <= req_wide_i;
          hi_q    <= 1'b0;
          split_q <= 1'b0;
          w16_q   <= 1'b0;
          err_q   <= 1'b0;
          rdata_q <= '0;
          st_q    <= ST_ADDR;
        end
        ST_ADDR: st_q <= ST_CMD;
        ST_CMD: begin
          w16_q   <= wide_now & claim;
          split_q <= wide_now & ~claim;
          st_q    <= ST_WAIT;
        end
        ST_WAIT: if (fin) begin
          st_q <= ST_END;
          if (tmo) err_q <= 1'b1;
        end
        ST_END: begin
          if (w16_q)     rdata_q         <= sd_i;
          else if (hi_q) rdata_q[BUS_W-1:HB] <= sd_i[HB-1:0];
          else           rdata_q[HB-1:0] <= sd_i[HB-1:0];
          if (split_q && !hi_q) begin
            hi_q <= 1'b1;
            st_q <= ST_ADDR;
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign bale_o      = (st_q == ST_ADDR);
  assign sa_o        = {addr_q[ADDR_W-1:1], addr_q[0] | hi_q};
  assign sbhe_no     = ~((st_q != ST_IDLE) & wide_now);
  assign sd_oe_o     = cmd_act & write_q;
  assign sd_o        = hi_q ? {wdata_q[BUS_W-1:HB], wdata_q[BUS_W-1:HB]} : wdata_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign tmo_err_o   = done_q & err_q;
endmodule

// File: rtl/isa_cycle_seq_chk.sv
module isa_cycle_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              tmo_err_o,
  input logic              bale_o,
  input logic [ADDR_W-1:0] sa_o,
  input logic              iorc_no,
  input logic              iowc_no,
  input logic              mrdc_no,
  input logic              mwtc_no,
  input logic              smrdc_no,
  input logic              smwtc_no,
  input logic              sd_oe_o
);
  logic cmd_on, low_mb;
  assign cmd_on = ~(iorc_no & iowc_no & mrdc_no & mwtc_no);
  assign low_mb = ~|sa_o[ADDR_W-1:LOW_W];

  AST_BALE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bale_o |=> !bale_o); // R1
  AST_NO_CMD_IN_BALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bale_o |-> !cmd_on); // R1
  AST_SA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_on |-> $stable(sa_o)); // R1
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~iorc_no, ~iowc_no, ~mrdc_no, ~mwtc_no})); // R14
  AST_SMEM_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_mb |-> (smrdc_no && smwtc_no)); // R13
  AST_SMEM_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_mb |-> (smrdc_no == mrdc_no && smwtc_no == mwtc_no)); // R13
  AST_OE_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> (!iowc_no || !mwtc_no)); // R12
  AST_TMO_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_err_o |-> done_o); // R8
  AST_DONE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!cmd_on && !bale_o)); // R11
endmodule

bind isa_cycle_seq isa_cycle_seq_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .tmo_err_o  (tmo_err_o),
  .bale_o     (bale_o),
  .sa_o       (sa_o),
  .iorc_no    (iorc_no),
  .iowc_no    (iowc_no),
  .mrdc_no    (mrdc_no),
  .mwtc_no    (mwtc_no),
  .smrdc_no   (smrdc_no),
  .smwtc_no   (smwtc_no),
  .sd_oe_o    (sd_oe_o)
);

// File: tb/isa_cycle_seq_tb.sv
module isa_cycle_seq_tb;
  localparam int AW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [15:0]   req_wdata_i = '0;
  logic          req_write_i = 1'b0, req_mem_i = 1'b0, req_wide_i = 1'b0;
  logic [7:0]    tmo_lim_i = 8'd20;
  logic          done_o, tmo_err_o, bale_o, sbhe_no, sd_oe_o;
  logic [15:0]   rdata_o, sd_o, sd_i;
  logic [AW-1:0] sa_o;
  logic          iorc_no, iowc_no, mrdc_no, mwtc_no, smrdc_no, smwtc_no;
  logic          chrdy_i, nows_ni, io16_ni, m16_ni;

  // slave model settings
  int   chrdy_k = 0;
  logic nows_on = 0, io16_on = 0, m16_on = 0, m16_bale = 0, m16_cmd = 0;
  int   jc = 0;
  logic cmd_act;

  int n_chk = 0, n_err = 0;
  int n_cmd, n_bale, n_sbhe, n_oe, n_ior, n_iow, n_mr, n_mw, n_smr, n_smw;
  logic [AW-1:0] sa_first, sa_last;
  logic [15:0]   sd_first, sd_last, r_data;
  logic          r_err;

  always #5 clk_i = ~clk_i;

  isa_cycle_seq #(.W16_WAITS(2)) u_dut (.*);

  assign cmd_act = ~(iorc_no & iowc_no & mrdc_no & mwtc_no);
  always @(negedge clk_i) jc <= cmd_act ? jc + 1 : 0;
  assign chrdy_i = ~(cmd_act && jc >= 2 && jc <= chrdy_k + 1);
  assign nows_ni = ~(nows_on & cmd_act);
  assign io16_ni = ~io16_on;
  assign m16_ni  = ~(m16_on | (m16_bale & bale_o) | (m16_cmd & cmd_act & (jc == 1)));
  assign sd_i    = {8'h5A ^ sa_o[7:0], 8'hC3 ^ sa_o[7:0]};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic slave(input int k, input logic nw, input logic i16, input logic m16,
                       input logic mb, input logic mc);
    chrdy_k = k; nows_on = nw; io16_on = i16; m16_on = m16; m16_bale = mb; m16_cmd = mc;
  endtask

  task automatic run(input logic [AW-1:0] a, input logic [15:0] wd,
                     input logic wr, input logic mem, input logic wide);
    int guard;
    n_cmd = 0; n_bale = 0; n_sbhe = 0; n_oe = 0; n_ior = 0; n_iow = 0;
    n_mr = 0; n_mw = 0; n_smr = 0; n_smw = 0;
    @(negedge clk_i);
    req_addr_i = a; req_wdata_i = wd; req_write_i = wr; req_mem_i = mem;
    req_wide_i = wide; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 2000) begin
      if (cmd_act) n_cmd++;
      if (bale_o) begin
        if (n_bale == 0) sa_first = sa_o;
        sa_last = sa_o;
        n_bale++;
      end
      if (sd_oe_o) begin
        if (n_oe == 0) sd_first = sd_o;
        sd_last = sd_o;
        n_oe++;
      end
      if (!sbhe_no)  n_sbhe++;
      if (!iorc_no)  n_ior++;
      if (!iowc_no)  n_iow++;
      if (!mrdc_no)  n_mr++;
      if (!mwtc_no)  n_mw++;
      if (!smrdc_no) n_smr++;
      if (!smwtc_no) n_smw++;
      @(negedge clk_i);
      guard++;
    end
    if (!done_o) chk("run did not complete", 0, 1);
    r_data = rdata_o;
    r_err  = tmo_err_o;
  endtask

  task automatic t_reset;
    chk("R14 reset strobes", {iorc_no, iowc_no, mrdc_no, mwtc_no, smrdc_no, smwtc_no}, 6'h3F);
    chk("R11 reset ready/done", {req_ready_o, done_o}, 2'b10);
    chk("R1 reset bale", bale_o, 0);
    chk("R12 reset oe", sd_oe_o, 0);
  endtask

  task automatic t_io8_read;
    slave(0, 0, 0, 0, 0, 0);
    run(24'h0002F8, 16'h0, 0, 0, 0);
    chk("R2 io8 cmd clocks", n_cmd, 6);
    chk("R1 io8 bale pulses", n_bale, 1);
    chk("R1 io8 address", sa_first, 24'h0002F8);
    chk("R14 io8 iorc only", n_ior, 6);
    chk("R11 io8 rdata", r_data, {8'h00, 8'hC3 ^ 8'hF8});
    chk("R8 io8 no timeout", r_err, 0);
    chk("R9 io8 sbhe high", n_sbhe, 0);
  endtask

  task automatic t_io8_write;
    slave(0, 0, 0, 0, 0, 0);
    run(24'h000378, 16'h00A7, 1, 0, 0);
    chk("R14 io8 write iowc", n_iow, 6);
    chk("R14 io8 write no iorc", n_ior, 0);
    chk("R12 io8 write oe clocks", n_oe, 6);
    chk("R12 io8 write data", sd_first[7:0], 8'hA7);
  endtask

  task automatic t_mem16_read;
    slave(0, 0, 0, 1, 0, 0);
    run(24'h0C1230, 16'h0, 0, 1, 1);
    chk("R3 mem16 cmd clocks", n_cmd, 4);
    chk("R9 mem16 sbhe clocks", n_sbhe, 5);
    chk("R9 mem16 single cycle", n_bale, 1);
    chk("R11 mem16 rdata", r_data, {8'h5A ^ 8'h30, 8'hC3 ^ 8'h30});
  endtask

  task automatic t_chrdy;
    slave(3, 0, 0, 0, 0, 0);
    run(24'h000300, 16'h0, 0, 0, 0);
    chk("R4 io8 chrdy 3 holds", n_cmd, 9);
    slave(2, 0, 0, 1, 0, 0);
    run(24'h0D0000, 16'h0, 0, 1, 1);
    chk("R4 mem16 chrdy 2 holds", n_cmd, 6);
  endtask

  task automatic t_nows;
    slave(0, 1, 0, 0, 0, 0);
    run(24'h000300, 16'h0, 0, 0, 0);
    chk("R5 io8 nows", n_cmd, 3);
    slave(0, 1, 0, 1, 0, 0);
    run(24'h0D0000, 16'h0, 0, 1, 1);
    chk("R5 mem16 nows", n_cmd, 3);
    slave(0, 1, 1, 0, 0, 0);
    run(24'h000300, 16'h0, 0, 0, 1);
    chk("R6 io16 nows ignored", n_cmd, 4);
    chk("R6 io16 claimed", n_bale, 1);
  endtask

  task automatic t_both;
    slave(2, 1, 0, 0, 0, 0);
    run(24'h000300, 16'h0, 0, 0, 0);
    chk("R7 chrdy over nows", n_cmd, 5);
  endtask

  task automatic t_timeout;
    tmo_lim_i = 8'd5;
    slave(100, 0, 0, 0, 0, 0);
    run(24'h000310, 16'h0, 0, 0, 0);
    chk("R8 timeout cmd clocks", n_cmd, 8);
    chk("R8 timeout flag", r_err, 1);
    slave(0, 0, 0, 0, 0, 0);
    run(24'h000310, 16'h0, 0, 0, 0);
    chk("R8 flag cleared", r_err, 0);
    chk("R8 normal after timeout", n_cmd, 6);
    tmo_lim_i = 8'd20;
  endtask

  task automatic t_split;
    slave(0, 0, 0, 0, 0, 0);
    run(24'h000240, 16'h0, 0, 0, 1);
    chk("R10 split bale pulses", n_bale, 2);
    chk("R10 split cmd clocks", n_cmd, 12);
    chk("R10 split second address", sa_last, 24'h000241);
    chk("R10 split sbhe first only", n_sbhe, 7);
    chk("R10 split rdata", r_data, {8'hC3 ^ 8'h41, 8'hC3 ^ 8'h40});
  endtask

  task automatic t_claim_rules;
    slave(0, 0, 1, 0, 0, 0);
    run(24'h0C0000, 16'h0, 0, 1, 1);
    chk("R9 io16 ignored on memory", n_bale, 2);
    slave(0, 0, 0, 1, 0, 0);
    run(24'h000300, 16'h0, 0, 0, 1);
    chk("R9 m16 ignored on io", n_bale, 2);
    slave(0, 0, 0, 0, 0, 1);
    run(24'h0C0000, 16'h0, 0, 1, 1);
    chk("R9 m16 second sample", n_bale, 1);
    slave(0, 0, 0, 0, 1, 0);
    run(24'h0C0000, 16'h0, 0, 1, 1);
    chk("R9 m16 first sample", n_bale, 1);
  endtask

  task automatic t_writes;
    slave(0, 0, 0, 0, 0, 0);
    run(24'h001000, 16'hBEEF, 1, 1, 1);
    chk("R12 split write oe clocks", n_oe, 12);
    chk("R10 split write low byte", sd_first[7:0], 8'hEF);
    chk("R10 split write high byte", sd_last[7:0], 8'hBE);
    chk("R13 split write smwtc", n_smw, 12);
    slave(0, 0, 0, 1, 0, 0);
    run(24'h0A0000, 16'h1234, 1, 1, 1);
    chk("R12 wide write oe clocks", n_oe, 4);
    chk("R12 wide write data", sd_first, 16'h1234);
    chk("R14 wide write mwtc", n_mw, 4);
  endtask

  task automatic t_low_mb;
    slave(0, 0, 0, 0, 0, 0);
    run(24'h0FFFFF, 16'h0, 0, 1, 0);
    chk("R13 below 1MB smrdc", n_smr, 6);
    chk("R14 below 1MB mrdc", n_mr, 6);
    run(24'h100000, 16'h0, 0, 1, 0);
    chk("R13 above 1MB smrdc", n_smr, 0);
    chk("R13 above 1MB mrdc", n_mr, 6);
    chk("R14 memory no iorc", n_ior, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_io8_read();
    t_io8_write();
    t_mem16_read();
    t_chrdy();
    t_nows();
    t_both();
    t_timeout();
    t_split();
    t_claim_rules();
    t_writes();
    t_low_mb();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule